// File: doc/BRIEF.md
# Three-Slot Asymmetric Decode Steering Stage

This stage sits after instruction length marking and before micro-op issue. Each cycle it can accept a group of up to three instructions whose boundaries are already known. Every instruction comes with a count of the micro-ops it expands into. The stage holds the group in a small window and steers the instructions to three decode slots that are not equal. The first slot handles any instruction of up to four micro-ops. The other two slots handle only single micro-op instructions. Instructions that need more micro-ops than the first slot can produce are handed to a microcode request output and are not expanded here.

Decoding follows program order. When an instruction that needs several micro-ops sits behind the oldest remaining instruction, decoding stops in front of it for that cycle. On the next cycle it becomes the oldest entry and is decoded in the first slot. All micro-ops that the chosen instructions produce go into a six-entry first-in first-out queue as one unit, and only when the queue has room for all of them. The queue presents up to three micro-ops per cycle on three output lanes, and each lane has its own valid and ready.

Top module: `idec_steer`

## Requirements
- R1: During and directly after a synchronous active-high reset, all three out_valid lanes and mc_valid are low, and in_ready is high.
- R2: Micro-ops leave in program order. An instruction of n micro-ops yields n consecutive queue entries. Each entry is {instruction data, index[1:0]}, with the index running 0..n-1. Lane i of out_data occupies bits [i*10 +: 10].
- R3: Each cycle the oldest instruction in the window goes to slot 0. Any count from 1 to 4 is expanded completely in that one cycle.
- R4: Slots 1 and 2 take only single micro-op instructions, in order, after slot 0. Steering stops before the first later instruction whose count is not 1. That instruction becomes the oldest and is decoded in slot 0 on the following cycle.
- R5: An oldest instruction with a count greater than 4 is consumed alone in its cycle and writes no micro-ops. On the next clock, mc_valid is high for exactly one cycle and mc_data carries its data.
- R6: A decode group (slot 0 plus the singles taken with it) is written in full or not at all. It waits while its total exceeds six minus the queue occupancy at the start of the cycle. Micro-ops popped in the same cycle do not count as free space.
- R7: The queue holds at most six micro-ops and never loses, duplicates or reorders any of them.
- R8: out_valid is a thermometer of the queue occupancy, capped at three lanes. Lane i is removed when it is valid, its out_ready is high, and every lower lane is also removed in that cycle.
- R9: in_ready is high when the window is empty or is emptied in the current cycle. On in_valid and in_ready, the window loads in_num (1 to 3) instructions. Instruction i takes data from in_data[i*8 +: 8] and its count from in_nuop[i*3 +: 3]. Counts range from 1 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction group is offered |
| in_ready | output | 1 | The window can load a group this cycle |
| in_num | input | 2 | Number of instructions in the group, 1 to 3 |
| in_data | input | 24 | Per-instruction data, 8 bits per instruction |
| in_nuop | input | 9 | Per-instruction micro-op count, 3 bits per instruction |
| out_valid | output | 3 | Lane valid, thermometer coded |
| out_ready | input | 3 | Lane ready from the consumer |
| out_data | output | 30 | Micro-op per lane: data and index, 10 bits per lane |
| mc_valid | output | 1 | One-cycle pulse for an instruction sent to microcode |
| mc_data | output | 8 | Data of that instruction |

## Verification
A window that has shifted wrongly shows up at the ports through in_ready. in_ready then rises one cycle early or late, and the next out_data values carry the wrong instruction or index as soon as the queue presents them, which is usually one clock after the decode. Corrupted queue pointers or a wrong occupancy count make a lane valid that should be idle, or make a micro-op appear twice or not at all. The first lane that is read afterwards shows this. A wrong stall decision shows up in the same cycle as an in_ready value that differs from the model, and as a missing or extra mc_valid pulse one clock later.

// File: rtl/idec_steer_pkg.sv
package idec_steer_pkg;

  // Ring index wrap for a queue whose depth need not be a power of two.
  // The argument stays below twice the depth in every caller.
  function automatic int ring_wrap(input int idx, input int depth);
    return (idx >= depth) ? (idx - depth) : idx;
  endfunction

  // Width that can hold the value n (at least one bit).
  function automatic int bits_for(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/idec_steer_window.sv
module idec_steer_window
  import idec_steer_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUOP_W    = 3,
  parameter int SLOT0_MAX = 4,
  parameter int NSLOT     = 3,
  parameter int QDEPTH    = 6,
  localparam int IDX_W = bits_for(SLOT0_MAX - 1),
  localparam int UOP_W = DATA_W + IDX_W,
  localparam int NUM_W = bits_for(NSLOT),
  localparam int MAXWR = SLOT0_MAX + NSLOT - 1,
  localparam int WRN_W = bits_for(MAXWR),
  localparam int CNT_W = bits_for(QDEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [NUM_W-1:0]          in_num,
  input  logic [NSLOT*DATA_W-1:0]   in_data,
  input  logic [NSLOT*NUOP_W-1:0]   in_nuop,
  output logic                      in_ready,
  input  logic [CNT_W-1:0]          q_free,
  output logic [WRN_W-1:0]          wr_n,
  output logic [MAXWR*UOP_W-1:0]    wr_data,
  output logic                      mc_fire,
  output logic [DATA_W-1:0]         mc_data
);

  // Window of pending instructions, oldest at index 0.
  logic [DATA_W-1:0] win_data [NSLOT];
  logic [NUOP_W-1:0] win_nuop [NSLOT];
  logic [NUM_W-1:0]  win_cnt;

  logic is_mc;
  logic fire;
  logic run;
  int   take_i;
  int   tot_i;

  // Slot assignment: slot 0 takes the oldest entry, later slots take
  // singles until the first entry that is not a single.
  always_comb begin
    is_mc  = (win_cnt != '0) && (int'(win_nuop[0]) > SLOT0_MAX);
    take_i = 0;
    tot_i  = 0;
    run    = 1'b1;
    if (win_cnt != '0) begin
      if (is_mc) begin
        take_i = 1;
      end else begin
        take_i = 1;
        tot_i  = int'(win_nuop[0]);
        for (int p = 1; p < NSLOT; p++) begin
          if (run && (p < int'(win_cnt)) && (win_nuop[p] == NUOP_W'(1))) begin
            take_i = take_i + 1;
            tot_i  = tot_i + 1;
          end else begin
            run = 1'b0;
          end
        end
      end
    end
    fire = is_mc || ((take_i != 0) && (tot_i <= int'(q_free)));
  end

  // Micro-op expansion for the chosen group, packed in program order.
  logic [UOP_W-1:0] wr_arr [MAXWR];
  int               wr_k;

  always_comb begin
    wr_arr = '{default: '0};
    wr_k   = 0;
    if (fire && !is_mc) begin
      for (int u = 0; u < SLOT0_MAX; u++) begin
        if ((u < int'(win_nuop[0])) && (wr_k < MAXWR)) begin
          wr_arr[wr_k] = {win_data[0], IDX_W'(u)};
          wr_k = wr_k + 1;
        end
      end
      for (int p = 1; p < NSLOT; p++) begin
        if ((p < take_i) && (wr_k < MAXWR)) begin
          wr_arr[wr_k] = {win_data[p], IDX_W'(0)};
          wr_k = wr_k + 1;
        end
      end
    end
  end

  for (genvar g = 0; g < MAXWR; g++) begin : g_wr_pack
    assign wr_data[g*UOP_W +: UOP_W] = wr_arr[g];
  end

  assign wr_n     = WRN_W'(wr_k);
  assign in_ready = (win_cnt == '0) || (fire && (take_i == int'(win_cnt)));
  assign mc_fire  = fire && is_mc;
  assign mc_data  = win_data[0];

  // Window update: shift out consumed entries, then load a fresh group.
  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
    end else begin
      if (fire) begin
        win_cnt <= win_cnt - NUM_W'(take_i);
        for (int p = 0; p < NSLOT; p++) begin
          if (p + take_i < NSLOT) begin
            win_data[p] <= win_data[p + take_i];
            win_nuop[p] <= win_nuop[p + take_i];
          end
        end
      end
      if (in_valid && in_ready) begin
        win_cnt <= (int'(in_num) > NSLOT) ? NUM_W'(NSLOT) : in_num;
        for (int p = 0; p < NSLOT; p++) begin
          win_data[p] <= in_data[p*DATA_W +: DATA_W];
          win_nuop[p] <= in_nuop[p*NUOP_W +: NUOP_W];
        end
      end
    end
  end

  // R9: an accepted group fills the window with exactly in_num entries.
  p_load_count_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_num != '0) && (int'(in_num) <= NSLOT))
      |=> (win_cnt == $past(in_num)));

  // R4: a multi-micro-op entry left behind moves to the front next cycle.
  p_advance_to_slot0_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && !is_mc && (take_i == 1) && (int'(win_cnt) > 1))
      |=> ((win_nuop[0] == $past(win_nuop[1])) && (win_data[0] == $past(win_data[1]))));

  // R6: a group that does not fit leaves the window untouched.
  p_hold_when_full_r6: assert property (@(posedge clk) disable iff (rst)
    ((win_cnt != '0) && !fire) |=> $stable(win_cnt));

endmodule

// File: rtl/idec_steer_uopq.sv
module idec_steer_uopq
  import idec_steer_pkg::*;
#(
  parameter int UOP_W = 10,
  parameter int DEPTH = 6,
  parameter int MAXWR = 6,
  parameter int NOUT  = 3,
  localparam int PTR_W = bits_for(DEPTH - 1),
  localparam int CNT_W = bits_for(DEPTH),
  localparam int WRN_W = bits_for(MAXWR)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WRN_W-1:0]        wr_n,
  input  logic [MAXWR*UOP_W-1:0]  wr_data,
  output logic [CNT_W-1:0]        free,
  output logic [NOUT-1:0]         out_valid,
  input  logic [NOUT-1:0]         out_ready,
  output logic [NOUT*UOP_W-1:0]   out_data
);

  logic [UOP_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] wr_ptr;
  logic [CNT_W-1:0] count;
  logic             run;
  int               pops;

  // Lanes leave in order; the first lane not taken blocks the rest.
  always_comb begin
    pops = 0;
    run  = 1'b1;
    for (int i = 0; i < NOUT; i++) begin
      if (run && (i < int'(count)) && out_ready[i]) pops = pops + 1;
      else run = 1'b0;
    end
  end

  // Storage written without reset so the array maps to plain registers.
  always_ff @(posedge clk) begin
    for (int k = 0; k < MAXWR; k++) begin
      if (k < int'(wr_n)) mem[PTR_W'(ring_wrap(int'(wr_ptr) + k, DEPTH))] <= wr_data[k*UOP_W +: UOP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= PTR_W'(ring_wrap(int'(rd_ptr) + pops, DEPTH));
      wr_ptr <= PTR_W'(ring_wrap(int'(wr_ptr) + int'(wr_n), DEPTH));
      count  <= CNT_W'(int'(count) + int'(wr_n) - pops);
    end
  end

  assign free = CNT_W'(DEPTH) - count;

  for (genvar g = 0; g < NOUT; g++) begin : g_lane
    assign out_valid[g] = (int'(count) > g);
    assign out_data[g*UOP_W +: UOP_W] = mem[PTR_W'(ring_wrap(int'(rd_ptr) + g, DEPTH))];
  end

  // R7: occupancy never passes the depth.
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(count) <= DEPTH));

  // R6: a write burst always fits in the space counted before pops.
  p_group_fits_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_n != '0) |-> (int'(wr_n) <= DEPTH - int'(count)));

endmodule

// File: rtl/idec_steer.sv
module idec_steer
  import idec_steer_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUOP_W    = 3,
  parameter int SLOT0_MAX = 4,
  parameter int NSLOT     = 3,
  parameter int QDEPTH    = 6,
  parameter int NOUT      = 3,
  localparam int IDX_W = bits_for(SLOT0_MAX - 1),
  localparam int UOP_W = DATA_W + IDX_W,
  localparam int NUM_W = bits_for(NSLOT),
  localparam int MAXWR = SLOT0_MAX + NSLOT - 1,
  localparam int WRN_W = bits_for(MAXWR),
  localparam int CNT_W = bits_for(QDEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NUM_W-1:0]         in_num,
  input  logic [NSLOT*DATA_W-1:0]  in_data,
  input  logic [NSLOT*NUOP_W-1:0]  in_nuop,
  output logic [NOUT-1:0]          out_valid,
  input  logic [NOUT-1:0]          out_ready,
  output logic [NOUT*UOP_W-1:0]    out_data,
  output logic                     mc_valid,
  output logic [DATA_W-1:0]        mc_data
);

  logic [CNT_W-1:0]       q_free;
  logic [WRN_W-1:0]       wr_n;
  logic [MAXWR*UOP_W-1:0] wr_data;
  logic                   mc_fire;
  logic [DATA_W-1:0]      mc_data_w;

  idec_steer_window #(
    .DATA_W(DATA_W), .NUOP_W(NUOP_W), .SLOT0_MAX(SLOT0_MAX),
    .NSLOT(NSLOT), .QDEPTH(QDEPTH)
  ) u_win (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_num(in_num), .in_data(in_data), .in_nuop(in_nuop),
    .in_ready(in_ready), .q_free(q_free),
    .wr_n(wr_n), .wr_data(wr_data),
    .mc_fire(mc_fire), .mc_data(mc_data_w)
  );

  idec_steer_uopq #(
    .UOP_W(UOP_W), .DEPTH(QDEPTH), .MAXWR(MAXWR), .NOUT(NOUT)
  ) u_q (
    .clk(clk), .rst(rst),
    .wr_n(wr_n), .wr_data(wr_data), .free(q_free),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // Registered microcode hand-off.
  always_ff @(posedge clk) begin
    if (rst) begin
      mc_valid <= 1'b0;
      mc_data  <= '0;
    end else begin
      mc_valid <= mc_fire;
      if (mc_fire) mc_data <= mc_data_w;
    end
  end

  // R5: the cycle that sent an instruction to microcode wrote no micro-ops.
  p_mc_no_uops_r5: assert property (@(posedge clk) disable iff (rst)
    mc_valid |-> ($past(wr_n) == '0));

endmodule

// File: tb/sim_idec_steer.sv
`timescale 1ns/1ps
module sim_idec_steer;
  localparam int DW = 8, NW = 3, NS = 3, QD = 6, NO = 3, UW = DW + 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [1:0]        in_num = 2'd1;
  logic [NS*DW-1:0]  in_data = '0;
  logic [NS*NW-1:0]  in_nuop = '0;
  logic [NO-1:0]     out_valid;
  logic [NO-1:0]     out_ready = '0;
  logic [NO*UW-1:0]  out_data;
  logic              mc_valid;
  logic [DW-1:0]     mc_data;

  always #2.5 clk = ~clk;

  idec_steer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_num(in_num), .in_data(in_data), .in_nuop(in_nuop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mc_valid(mc_valid), .mc_data(mc_data)
  );

  int checks = 0;
  int fails  = 0;
  string tag = "reset";

  // Behavioural model state.
  int  win_d[$];
  int  win_n[$];
  int  q[$];
  bit  mcv = 0;
  int  mcd = 0;
  int  ddata = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, compare outputs, advance the model.
  task automatic cycle(input bit v, input int num, input int n0, input int n1,
                       input int n2, input logic [2:0] rdy, output bit acc);
    int wn, take, tot, pops;
    bit mc, fire, rdy_exp;
    @(negedge clk);
    in_valid  = v;
    in_num    = 2'(num);
    in_data   = {8'(ddata + 2), 8'(ddata + 1), 8'(ddata)};
    in_nuop   = {3'(n2), 3'(n1), 3'(n0)};
    out_ready = rdy;
    #1;
    wn = win_d.size(); take = 0; tot = 0; mc = 0; fire = 0;
    if (wn > 0) begin
      if (win_n[0] > 4) begin
        mc = 1; take = 1; fire = 1;
      end else begin
        take = 1; tot = win_n[0];
        for (int p = 1; p < wn; p++) begin
          if (win_n[p] == 1) begin take++; tot++; end
          else break;
        end
        fire = (tot <= QD - q.size());
      end
    end
    rdy_exp = (wn == 0) || (fire && take == wn);
    chk("R9 in_ready", int'(in_ready), int'(rdy_exp));
    for (int i = 0; i < NO; i++) begin
      chk("R8 out_valid", int'(out_valid[i]), int'(q.size() > i));
      if (q.size() > i) chk("R2 out_data", int'(out_data[i*UW +: UW]), q[i]);
    end
    chk("R5 mc_valid", int'(mc_valid), int'(mcv));
    if (mcv) chk("R5 mc_data", int'(mc_data), mcd);
    pops = 0;
    for (int i = 0; i < NO; i++) begin
      if (i < q.size() && rdy[i]) pops++;
      else break;
    end
    repeat (pops) void'(q.pop_front());
    mcv = 0;
    if (fire) begin
      if (mc) begin
        mcv = 1; mcd = win_d[0];
      end else begin
        for (int u = 0; u < win_n[0]; u++) q.push_back(win_d[0] * 4 + u);
        for (int p = 1; p < take; p++) q.push_back(win_d[p] * 4);
      end
      repeat (take) begin void'(win_d.pop_front()); void'(win_n.pop_front()); end
    end
    acc = rdy_exp && v;
    if (acc) begin
      for (int i = 0; i < num; i++) begin
        win_d.push_back((ddata + i) % 256);
        win_n.push_back(i == 0 ? n0 : (i == 1 ? n1 : n2));
      end
      ddata = (ddata + 3) % 256;
    end
  endtask

  task automatic send(input int num, input int n0, input int n1, input int n2,
                      input logic [2:0] rdy);
    bit acc;
    for (int t = 0; t < 40; t++) begin
      cycle(1, num, n0, n1, n2, rdy, acc);
      if (acc) break;
    end
  endtask

  task automatic idle(input int n, input logic [2:0] rdy);
    bit acc;
    for (int t = 0; t < n; t++) cycle(0, 1, 1, 1, 1, rdy, acc);
  endtask

  initial begin
    bit acc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 mc_valid", int'(mc_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    rst = 1'b0;

    tag = "R3 slot0 multi";
    send(3, 4, 1, 1, 3'b111);
    send(3, 3, 1, 1, 3'b111);
    send(1, 2, 1, 1, 3'b111);
    send(2, 4, 1, 1, 3'b111);
    idle(5, 3'b111);

    tag = "R4 late multi";
    send(3, 1, 2, 1, 3'b111);
    send(3, 1, 1, 4, 3'b111);
    send(3, 2, 3, 4, 3'b111);
    send(3, 1, 3, 1, 3'b111);
    idle(6, 3'b111);

    tag = "R5 microcode";
    send(3, 5, 1, 1, 3'b111);
    send(3, 1, 7, 1, 3'b111);
    send(3, 7, 6, 5, 3'b111);
    idle(5, 3'b111);

    tag = "R6 whole group";
    send(3, 4, 1, 1, 3'b000);
    send(3, 1, 1, 1, 3'b000);
    idle(3, 3'b000);
    idle(1, 3'b001);
    idle(8, 3'b111);

    tag = "R7 depth";
    send(3, 1, 1, 1, 3'b000);
    send(3, 1, 1, 1, 3'b000);
    send(1, 4, 1, 1, 3'b000);
    idle(2, 3'b000);
    idle(6, 3'b011);

    tag = "R8 lane ready";
    send(3, 2, 1, 1, 3'b101);
    send(3, 1, 1, 1, 3'b010);
    send(3, 3, 1, 1, 3'b011);
    idle(8, 3'b101);
    idle(6, 3'b111);

    tag = "R2 random";
    for (int t = 0; t < 3000; t++) begin
      int r0, r1, r2, nn;
      r0 = $urandom % 10; r1 = $urandom % 10; r2 = $urandom % 10;
      r0 = (r0 < 5) ? 1 : (r0 < 8 ? 2 + (r0 % 3) : 5 + (r0 % 3));
      r1 = (r1 < 5) ? 1 : (r1 < 8 ? 2 + (r1 % 3) : 5 + (r1 % 3));
      r2 = (r2 < 5) ? 1 : (r2 < 8 ? 2 + (r2 % 3) : 5 + (r2 % 3));
      nn = 1 + ($urandom % 3);
      cycle(bit'($urandom % 2), nn, r0, r1, r2, 3'($urandom), acc);
    end
    idle(10, 3'b111);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule